// File: doc/BRIEF.md
# Immediate-Masked Packed Word Blend Unit

This unit merges two 256-bit vector operands one 16-bit word at a time. An 8-bit mask byte decides, for each word, which operand supplies it. The unit sits in a SIMD execution pipe after operand fetch. A mode input selects one of three forms. The legacy 128-bit form treats the first operand as the old destination and keeps its upper half. The three-operand 128-bit form clears the upper half. The 256-bit form applies the same mask byte again to the upper half.

The result is registered once. A request for the wide form while the wide-form enable is low raises a one-cycle undefined-instruction fault and updates no result. A request with the reserved mode code does the same. No status flags or numeric exceptions come from this unit.

Top module: `wblend_unit`

## Requirements
- R1: Word k (bits 16k+15:16k, k = 0..7) of the lower half of out_data equals word k of src_b when sel_mask[k] is 1, and word k of src_a when it is 0.
- R2: In the wide mode (in_mode = 2'b10, wide_en = 1), word k+8 of out_data is chosen by the same sel_mask[k]: src_b when 1, src_a when 0.
- R3: In the legacy mode (in_mode = 2'b00), out_data[255:128] equals src_a[255:128], because the first operand is the old destination value.
- R4: In the three-operand narrow mode (in_mode = 2'b01), out_data[255:128] is zero.
- R5: A wide-mode request with wide_en = 0 raises out_fault, keeps out_valid low, and leaves out_data unchanged.
- R6: A request with in_mode = 2'b11 raises out_fault, keeps out_valid low, and leaves out_data unchanged.
- R7: out_fault is high for exactly one cycle per faulting request, in the cycle where the result would have appeared.
- R8: out_valid follows in_valid by one clock for every request that does not fault. The result appears in that same cycle.
- R9: While rst is high, out_data, out_valid and out_fault are zero on the next clock.
- R10: A cycle with in_valid low produces neither out_valid nor out_fault in the following cycle, and out_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | 00 legacy narrow, 01 three-operand narrow, 10 wide, 11 reserved |
| wide_en | input | 1 | Feature enable for the wide form |
| src_a | input | 256 | First operand, also the old destination value |
| src_b | input | 256 | Second operand |
| sel_mask | input | 8 | Per-word select byte |
| out_data | output | 256 | Registered blend result |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_fault | output | 1 | Undefined-instruction fault pulse |

## Verification
A broken lane mux or a crossed mask bit shows up as one wrong 16-bit word in out_data in the cycle right after the request. A wrong upper-half policy corrupts bits 255:128 for only the affected modes, and that error is also visible one cycle later. A faulty decode either drops out_valid on a legal request, or lets a faulting request overwrite out_data. Both errors are visible in the result cycle, and the stale data can still be read on later idle cycles.

// File: rtl/wblend_pkg.sv
package wblend_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_ZERO = 2'b01,
        MODE_WIDE = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        UP_KEEP = 2'd0,
        UP_ZERO = 2'd1,
        UP_CALC = 2'd2
    } upper_e;

    typedef struct packed {
        logic   fault;
        upper_e upper;
    } dec_t;

    function automatic dec_t decode_mode(logic [1:0] mode, logic wide_en);
        dec_t d;
        d.fault = 1'b0;
        d.upper = UP_KEEP;
        case (mode_e'(mode))
            MODE_KEEP: d.upper = UP_KEEP;
            MODE_ZERO: d.upper = UP_ZERO;
            MODE_WIDE: begin
                d.upper = UP_CALC;
                d.fault = !wide_en;
            end
            default:   d.fault = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wblend_decode.sv
module wblend_decode
    import wblend_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       wide_en,
    output dec_t       dec
);
    always_comb dec = decode_mode(mode, wide_en);
endmodule

// File: rtl/wblend_half.sv
module wblend_half #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    localparam int HALF_W = LANE_W * LANES
) (
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    input  logic [LANES-1:0]  mask,
    output logic [HALF_W-1:0] y
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign y[k*LANE_W +: LANE_W] = mask[k] ? b[k*LANE_W +: LANE_W]
                                               : a[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/wblend_unit.sv
module wblend_unit
    import wblend_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [1:0]                  in_mode,
    input  logic                        wide_en,
    input  logic [2*LANE_W*LANES-1:0]   src_a,
    input  logic [2*LANE_W*LANES-1:0]   src_b,
    input  logic [LANES-1:0]            sel_mask,
    output logic [2*LANE_W*LANES-1:0]   out_data,
    output logic                        out_valid,
    output logic                        out_fault
);
    localparam int HALF_W = LANE_W * LANES;
    localparam int VEC_W  = 2 * HALF_W;

    dec_t              dec;
    logic [VEC_W-1:0]  blended;
    logic [HALF_W-1:0] upper;
    logic              accept;

    wblend_decode u_dec (
        .mode    (in_mode),
        .wide_en (wide_en),
        .dec     (dec)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        wblend_half #(.LANE_W(LANE_W), .LANES(LANES)) u_half (
            .a    (src_a[h*HALF_W +: HALF_W]),
            .b    (src_b[h*HALF_W +: HALF_W]),
            .mask (sel_mask),
            .y    (blended[h*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        case (dec.upper)
            UP_CALC: upper = blended[VEC_W-1:HALF_W];
            UP_ZERO: upper = '0;
            default: upper = src_a[VEC_W-1:HALF_W];
        endcase
    end

    assign accept = in_valid && !dec.fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= accept;
            out_fault <= in_valid && dec.fault;
            if (accept) out_data <= {upper, blended[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/wblend_chk.sv
module wblend_chk #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_mode,
    input logic             wide_en,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_fault
);
    localparam int H = VEC_W / 2;

    // R3
    a_r3_keep_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b00) |=> out_data[VEC_W-1:H] == $past(src_a[VEC_W-1:H]));
    // R4
    a_r4_zero_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01) |=> out_data[VEC_W-1:H] == '0);
    // R5
    a_r5_wide_off: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b10 && !wide_en) |=> out_fault && !out_valid);
    // R6
    a_r6_reserved: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11) |=> out_fault && !out_valid);
    // R5, R6: a fault never updates the result
    a_r6_fault_hold: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> $stable(out_data));
    // R7
    a_r7_fault_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_fault && out_valid));
    // R8
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mode[1] == 1'b0 || (in_mode == 2'b10 && wide_en))) |=> out_valid);
    // R10
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_fault && $stable(out_data)));
endmodule

bind wblend_unit wblend_chk #(.VEC_W(2*LANE_W*LANES)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .wide_en(wide_en), .src_a(src_a), .out_data(out_data),
    .out_valid(out_valid), .out_fault(out_fault)
);

// File: tb/wblend_unit_bench.sv
module wblend_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mode = 2'b00;
    logic         wide_en = 1'b1;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic [7:0]   sel_mask = '0;
    logic [255:0] out_data;
    logic         out_valid;
    logic         out_fault;

    int checks = 0;
    int errors = 0;
    logic [255:0] last_good = '0;

    always #4 clk = ~clk;

    wblend_unit u_wblend_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .wide_en(wide_en), .src_a(src_a), .src_b(src_b), .sel_mask(sel_mask),
        .out_data(out_data), .out_valid(out_valid), .out_fault(out_fault)
    );

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] model(logic [1:0] m, logic [255:0] a,
                                           logic [255:0] b, logic [7:0] k);
        logic [255:0] r;
        for (int w = 0; w < 16; w++) begin
            r[w*16 +: 16] = k[w % 8] ? b[w*16 +: 16] : a[w*16 +: 16];
        end
        if (m == 2'b00) r[255:128] = a[255:128];
        else if (m == 2'b01) r[255:128] = '0;
        return r;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(string req, logic [1:0] m, logic en,
                          logic [255:0] a, logic [255:0] b, logic [7:0] k);
        logic bad;
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; wide_en = en;
        src_a = a; src_b = b; sel_mask = k;
        bad = (m == 2'b11) || (m == 2'b10 && !en);
        @(posedge clk); #1;
        if (bad) begin
            check({req, " fault"}, {255'd0, out_fault}, 256'd1);
            check({req, " no valid"}, {255'd0, out_valid}, 256'd0);
            check({req, " data held"}, out_data, last_good);
        end else begin
            last_good = model(m, a, b, k);
            check({req, " R8 valid"}, {255'd0, out_valid}, 256'd1);
            check({req, " data"}, out_data, last_good);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset data", out_data, '0);
        check("R9 reset valid/fault", {254'd0, out_valid, out_fault}, 256'd0);
        @(negedge clk); rst = 1'b0;

        // R1 R2 R3 R4: every mask value in every legal mode
        for (int k = 0; k < 256; k++) begin
            run_op("R1 R3", 2'b00, 1'b1, rnd256(), rnd256(), 8'(k));
            run_op("R1 R4", 2'b01, 1'b1, rnd256(), rnd256(), 8'(k));
            run_op("R2", 2'b10, 1'b1, rnd256(), rnd256(), 8'(k));
        end
        run_op("R2 all-ones", 2'b10, 1'b1, '0, '1, 8'hFF);
        run_op("R2 all-zeros", 2'b10, 1'b1, '1, '0, 8'h00);

        // R5 R6 R7: faults then the pulse must end
        run_op("R5", 2'b10, 1'b0, rnd256(), rnd256(), 8'hA5);
        @(posedge clk); #1;
        check("R7 single pulse", {255'd0, out_fault}, 256'd0);
        run_op("R6", 2'b11, 1'b1, rnd256(), rnd256(), 8'h3C);
        @(posedge clk); #1;
        check("R7 single pulse", {255'd0, out_fault}, 256'd0);

        // R10: idle cycles with inputs changing
        src_a = rnd256(); src_b = rnd256(); sel_mask = 8'hFF; in_mode = 2'b01;
        repeat (2) @(posedge clk);
        #1;
        check("R10 idle strobes", {254'd0, out_valid, out_fault}, 256'd0);
        check("R10 idle data", out_data, last_good);

        // R9: reset mid-run
        run_op("R8", 2'b00, 1'b1, '1, '1, 8'h0F);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R9 reset again", out_data, '0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule